// File: doc/BRIEF.md
# Protected Data EEPROM Register Controller

This block sits between a CPU-side register bus and a small on-chip byte array that stands in for nonvolatile data storage. Software sees four byte-wide registers: an address pointer, a data byte, a control/status byte and a write-only key register. A read is a single strobe. After the strobe, the addressed byte appears in the data register on the following clock.

Writes are deliberately awkward to reach. A separate enable bit must already be set by an earlier bus access. The key register must then receive the byte 55h and after it the byte AAh. The next bus write must go to the control register and set the start bit. Only then does an internal timer of programmable length run. At the end of that timer the array is updated, the start bit drops and a sticky completion flag is raised and driven onto an interrupt-style output. While the timer runs, the address, data and control registers cannot be changed. Every byte needs a fresh key sequence.

Register select encoding on `bus_sel`: 0 = address, 1 = data, 2 = control, 3 = key. Control bit layout: bit 0 read strobe, bit 1 write start/busy, bit 2 write enable, bit 4 completion flag, bit 7 space select (0 = data array). Bits 3, 5 and 6 read as 0.

Top module: `nv_data_ctrl`

## Requirements
- R1: After reset the address, data and control registers read 0, the key register reads 0, and `busy` and `done_irq` are 0.
- R2: A bus write to the control register (sel 2) with bit 0 = 1 and bit 7 = 0 loads the data register with the array byte at the current address on the following clock edge. Bit 0 reads back as 0 from then on.
- R3: The data register (sel 1) keeps its value until another read strobe completes or the bus writes it. A bus write to it reads back unchanged.
- R4: While control bit 7 is 1, or when bit 7 = 1 in the same control write, read strobes and write starts have no effect on the data register or the array. Bit 7 reads back as written.
- R5: A write starts only if the key register (sel 3) received 55h, then AAh, and the next bus write is to the control register with bit 1 = 1. A wrong key value, keys in the wrong order, or any other register write in between cancels the attempt.
- R6: One key sequence allows exactly one write. A second start request without a new key sequence does not start a write.
- R7: A write starts only if control bit 2 (write enable) was already 1 before the starting bus write. Setting bits 1 and 2 in the same write starts nothing, but it still sets bit 2.
- R8: Hardware never clears the write enable bit; it still reads 1 after a write completes.
- R9: Once started, `busy` and control bit 1 stay 1 for exactly WR_CYCLES clock cycles. The array byte at the address is then replaced by the data register, bit 1 clears, and the completion flag (bit 4) is set.
- R10: While `busy` is 1, bus writes to the address, data and control registers and read strobes are ignored.
- R11: The completion flag stays set, with `done_irq` equal to it, until a control write with bit 4 = 0. A control write with bit 4 = 1 leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe for one cycle |
| bus_sel | input | 2 | Register select for both write and read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register (combinational) |
| busy | output | 1 | Write cycle in progress |
| done_irq | output | 1 | Sticky completion flag |

## Verification
Random address and data pairs are each written with the full key sequence and then read back. This separates correct array addressing and timer length from stale or misplaced bytes. Directed sequences change one step of the key protocol at a time: swapped keys, a wrong key, an intervening register write, a missing enable, a repeated start and a set space bit. Each of these must leave `busy` low and the array unchanged, which separates the exact ordering rule from a looser key check. Bus writes issued during the timer show whether the freeze holds, and the flag sequence shows whether the flag is sticky and how it is cleared.

// File: rtl/nvd_pkg.sv
package nvd_pkg;

   typedef enum logic [1:0] {
      SEL_ADDR = 2'd0,
      SEL_DATA = 2'd1,
      SEL_CTRL = 2'd2,
      SEL_KEY  = 2'd3
   } nvd_sel_e;

   typedef enum logic [1:0] {
      UL_IDLE  = 2'd0,
      UL_HALF  = 2'd1,
      UL_ARMED = 2'd2
   } ul_state_e;

   localparam int CB_RD    = 0;
   localparam int CB_WR    = 1;
   localparam int CB_WREN  = 2;
   localparam int CB_DONE  = 4;
   localparam int CB_SPACE = 7;

   localparam int BYTE_W = 8;

   localparam logic [BYTE_W-1:0] KEY_FIRST  = 8'h55;
   localparam logic [BYTE_W-1:0] KEY_SECOND = 8'hAA;

endpackage

// File: rtl/nvd_unlock.sv
module nvd_unlock
   import nvd_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_wr,
   input  logic [BYTE_W-1:0] key_val,
   input  logic              cancel,
   output logic              armed
);

   ul_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (cancel) begin
         state_d = UL_IDLE;
      end else if (key_wr) begin
         unique case (state_q)
            UL_IDLE:  state_d = (key_val == KEY_FIRST)  ? UL_HALF  : UL_IDLE;
            UL_HALF:  state_d = (key_val == KEY_SECOND) ? UL_ARMED : UL_IDLE;
            default:  state_d = UL_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= UL_IDLE;
      else        state_q <= state_d;
   end

   assign armed = (state_q == UL_ARMED);

   AST_ARM_NEEDS_HALF: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == UL_ARMED && $past(state_q) != UL_ARMED) |-> ($past(state_q) == UL_HALF && $past(key_wr) && $past(key_val) == KEY_SECOND)); // R5
   AST_CANCEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      cancel |=> state_q == UL_IDLE); // R5

endmodule

// File: rtl/nvd_wtimer.sv
module nvd_wtimer #(
   parameter int CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic finish
);

   localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

   if (CYCLES < 2) begin : g_bad_cycles
      $error("nvd_wtimer: CYCLES must be at least 2");
   end

   logic          busy_q;
   logic [CW-1:0] cnt_q;

   assign finish = busy_q && (cnt_q == LAST);
   assign busy   = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
      end else if (finish) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (busy_q) begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy_q); // R10
   AST_COUNT_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> cnt_q == '0); // R9
   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && $past(busy_q) && !$past(finish)) |-> cnt_q == $past(cnt_q) + 1'b1); // R9

endmodule

// File: rtl/nvd_store.sv
module nvd_store
   import nvd_pkg::*;
#(
   parameter int AW    = 6,
   parameter int DEPTH = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     addr,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] rdata
);

   localparam int SPAN = 1 << AW;

   if (DEPTH < 1 || DEPTH > SPAN) begin : g_bad_depth
      $error("nvd_store: DEPTH must lie in 1 .. 2**AW");
   end

   logic [BYTE_W-1:0] mem_q [DEPTH];

   if (DEPTH == SPAN) begin : g_full
      assign rdata = mem_q[addr];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
         end else if (we) begin
            mem_q[addr] <= wdata;
         end
      end
   end else begin : g_partial
      logic in_range;
      assign in_range = (int'(addr) < DEPTH);
      assign rdata    = in_range ? mem_q[addr] : '0;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
         end else if (we && in_range) begin
            mem_q[addr] <= wdata;
         end
      end
   end

endmodule

// File: rtl/nv_data_ctrl.sv
module nv_data_ctrl
   import nvd_pkg::*;
#(
   parameter int AW        = 6,
   parameter int DEPTH     = 64,
   parameter int WR_CYCLES = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_wr,
   input  logic [1:0] bus_sel,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   output logic       busy,
   output logic       done_irq
);

   if (AW < 1 || AW > BYTE_W) begin : g_bad_aw
      $error("nv_data_ctrl: AW must lie in 1 .. 8");
   end

   logic [AW-1:0]     addr_q;
   logic [BYTE_W-1:0] data_q;
   logic              space_q, wren_q, flag_q, rd_q;
   logic [BYTE_W-1:0] mem_rdata;
   logic              armed, finish, start, rd_set;
   logic              wr_addr, wr_data, wr_ctrl, wr_key, key_ok, cancel;
   logic              unused_bits;

   assign unused_bits = ^{bus_wdata[6:5], bus_wdata[3]};

   assign wr_addr = bus_wr && (bus_sel == SEL_ADDR) && !busy;
   assign wr_data = bus_wr && (bus_sel == SEL_DATA) && !busy;
   assign wr_ctrl = bus_wr && (bus_sel == SEL_CTRL) && !busy;
   assign wr_key  = bus_wr && (bus_sel == SEL_KEY);
   assign key_ok  = wr_key && !busy;
   assign cancel  = bus_wr && !key_ok;

   assign start  = wr_ctrl && armed && wren_q
                   && bus_wdata[CB_WR] && !bus_wdata[CB_SPACE];
   assign rd_set = wr_ctrl && bus_wdata[CB_RD] && !bus_wdata[CB_SPACE] && !start;

   nvd_unlock i_unlock (
      .clk     (clk),
      .rst_n   (rst_n),
      .key_wr  (key_ok),
      .key_val (bus_wdata),
      .cancel  (cancel),
      .armed   (armed)
   );

   nvd_wtimer #(.CYCLES(WR_CYCLES)) i_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .busy   (busy),
      .finish (finish)
   );

   nvd_store #(.AW(AW), .DEPTH(DEPTH)) i_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (finish),
      .addr  (addr_q),
      .wdata (data_q),
      .rdata (mem_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         data_q  <= '0;
         space_q <= 1'b0;
         wren_q  <= 1'b0;
         flag_q  <= 1'b0;
         rd_q    <= 1'b0;
      end else begin
         rd_q <= rd_set;
         if (wr_addr) addr_q <= bus_wdata[AW-1:0];
         if (rd_q)         data_q <= mem_rdata;
         else if (wr_data) data_q <= bus_wdata;
         if (wr_ctrl) begin
            space_q <= bus_wdata[CB_SPACE];
            wren_q  <= bus_wdata[CB_WREN];
            if (!bus_wdata[CB_DONE]) flag_q <= 1'b0;
         end
         if (finish) flag_q <= 1'b1;
      end
   end

   always_comb begin
      unique case (bus_sel)
         SEL_ADDR: bus_rdata = BYTE_W'(addr_q);
         SEL_DATA: bus_rdata = data_q;
         SEL_CTRL: bus_rdata = {space_q, 2'b00, flag_q, 1'b0, wren_q, busy, rd_q};
         default:  bus_rdata = '0;
      endcase
   end

   assign done_irq = flag_q;

   AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_q |=> !rd_q); // R2
   AST_FREEZE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(addr_q)); // R10
   AST_FREEZE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(data_q)); // R10
   AST_START_NEEDS_WREN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(wren_q)); // R7
   AST_START_DATA_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !space_q); // R4
   AST_FLAG_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> flag_q); // R9
   AST_WREN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> wren_q); // R8
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !$past(flag_q) == 1'b0 && !wr_ctrl) |=> flag_q); // R11

endmodule

// File: tb/test_nv_data_ctrl.sv
module test_nv_data_ctrl;

   localparam int AW = 6;
   localparam int DEPTH = 64;
   localparam int WR_CYCLES = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic [1:0] bus_sel = 2'd0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       busy, done_irq;

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 0;

   logic [7:0] model [DEPTH];
   logic [7:0] exp_data;
   logic [AW-1:0] exp_addr;
   logic exp_wren, exp_flag, exp_space;

   nv_data_ctrl #(.AW(AW), .DEPTH(DEPTH), .WR_CYCLES(WR_CYCLES)) i_nv_data_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy), .done_irq(done_irq)
   );

   always #10 clk = ~clk;

   function automatic logic [7:0] ctrl_exp(input logic sp, input logic fl,
                                           input logic we, input logic bz);
      return {sp, 2'b00, fl, 1'b0, we, bz, 1'b0};
   endfunction

   task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", tag, got, exp);
      end
   endtask

   task automatic bwr(input logic [1:0] sel, input logic [7:0] val);
      bus_wr = 1'b1; bus_sel = sel; bus_wdata = val;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic peek(input logic [1:0] sel, output logic [7:0] v);
      bus_sel = sel;
      #1;
      v = bus_rdata;
   endtask

   task automatic do_read(input logic [AW-1:0] a);
      bwr(2'd0, 8'(a));
      bwr(2'd2, {1'b0, 2'b00, exp_flag, 1'b0, exp_wren, 1'b0, 1'b1});
      @(negedge clk);
      exp_addr = a;
      exp_data = model[a];
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      while (busy && n < 1000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d, input string tag);
      int n;
      logic [7:0] v;
      bwr(2'd0, 8'(a));
      bwr(2'd1, d);
      bwr(2'd2, 8'h04);
      bwr(2'd3, 8'h55);
      bwr(2'd3, 8'hAA);
      bwr(2'd2, 8'h06);
      exp_wren = 1; exp_flag = 0; exp_space = 0;
      wait_idle(n);
      check({tag, " R9 busy length"}, 8'(n), 8'(WR_CYCLES));
      model[a] = d;
      exp_addr = a; exp_data = d; exp_flag = 1;
      peek(2'd2, v);
      check({tag, " R8 R9 ctrl after write"}, v, ctrl_exp(0, 1, 1, 0));
      check({tag, " R11 done_irq"}, 8'(done_irq), 8'h01);
   endtask

   task automatic expect_no_start(input string tag);
      logic [7:0] v;
      check({tag, " busy"}, 8'(busy), 8'h00);
      @(negedge clk);
      peek(2'd2, v);
      check({tag, " ctrl"}, v, ctrl_exp(exp_space, exp_flag, exp_wren, 0));
   endtask

   task automatic check_array(input logic [AW-1:0] a, input string tag);
      logic [7:0] v;
      do_read(a);
      peek(2'd1, v);
      check(tag, v, model[a]);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      int n;
      void'($urandom(32'd2024));
      for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
      exp_data = 0; exp_addr = 0; exp_wren = 0; exp_flag = 0; exp_space = 0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int s = 0; s < 4; s++) begin
         peek(2'(s), v);
         check("R1 reset register", v, 8'h00);
      end
      check("R1 reset busy", 8'(busy), 8'h00);
      check("R1 reset done_irq", 8'(done_irq), 8'h00);

      // R2 basic read and write
      do_write(6'd5, 8'hC3, "R5 first write");
      do_read(6'd5);
      peek(2'd1, v);
      check("R2 read data", v, 8'hC3);
      peek(2'd2, v);
      check("R2 read strobe cleared", v, ctrl_exp(0, exp_flag, exp_wren, 0));

      // R3 data register retention and bus write
      repeat (4) @(negedge clk);
      peek(2'd1, v);
      check("R3 data held", v, 8'hC3);
      bwr(2'd1, 8'h3C);
      repeat (3) @(negedge clk);
      peek(2'd1, v);
      check("R3 data write", v, 8'h3C);
      exp_data = 8'h3C;

      // R4 space bit blocks read
      bwr(2'd0, 8'd5);
      bwr(2'd2, 8'h85);
      exp_space = 1; exp_wren = 1; exp_flag = 0;
      @(negedge clk);
      peek(2'd1, v);
      check("R4 read blocked by space bit", v, 8'h3C);
      // R4 space bit blocks write start
      bwr(2'd3, 8'h55);
      bwr(2'd3, 8'hAA);
      bwr(2'd2, 8'h86);
      expect_no_start("R4 write blocked by space bit");
      bwr(2'd2, 8'h04);
      exp_space = 0;
      check_array(6'd5, "R4 array unchanged");

      // R5 swapped key order
      bwr(2'd1, 8'h77);
      bwr(2'd3, 8'hAA);
      bwr(2'd3, 8'h55);
      bwr(2'd2, 8'h06);
      expect_no_start("R5 swapped keys");
      // R5 register write between keys
      bwr(2'd3, 8'h55);
      bwr(2'd0, 8'd5);
      bwr(2'd3, 8'hAA);
      bwr(2'd2, 8'h06);
      expect_no_start("R5 write between keys");
      // R5 register write between key and start
      bwr(2'd3, 8'h55);
      bwr(2'd3, 8'hAA);
      bwr(2'd1, 8'h77);
      bwr(2'd2, 8'h06);
      expect_no_start("R5 write before start");
      // R5 wrong second key
      bwr(2'd3, 8'h55);
      bwr(2'd3, 8'hAB);
      bwr(2'd2, 8'h06);
      expect_no_start("R5 wrong key");
      check_array(6'd5, "R5 array unchanged");

      // R7 enable set in the same write as start
      bwr(2'd2, 8'h00);
      exp_wren = 0;
      bwr(2'd0, 8'd9);
      bwr(2'd1, 8'h99);
      bwr(2'd3, 8'h55);
      bwr(2'd3, 8'hAA);
      bwr(2'd2, 8'h06);
      exp_wren = 1;
      expect_no_start("R7 enable and start together");
      check_array(6'd9, "R7 array unchanged");

      // R6 second start without a new key sequence
      do_write(6'd12, 8'h5A, "R6 setup");
      bwr(2'd1, 8'hEE);
      bwr(2'd2, 8'h16);
      expect_no_start("R6 repeated start");
      check_array(6'd12, "R6 array unchanged");

      // R11 flag sticky and cleared by software
      do_write(6'd20, 8'h81, "R11 setup");
      repeat (5) @(negedge clk);
      check("R11 flag held", 8'(done_irq), 8'h01);
      bwr(2'd2, 8'h14);
      check("R11 flag kept by bit4=1", 8'(done_irq), 8'h01);
      bwr(2'd2, 8'h04);
      exp_flag = 0;
      check("R11 flag cleared", 8'(done_irq), 8'h00);

      // R10 writes during busy are ignored
      bwr(2'd0, 8'd33);
      bwr(2'd1, 8'h42);
      bwr(2'd3, 8'h55);
      bwr(2'd3, 8'hAA);
      bwr(2'd2, 8'h06);
      bwr(2'd0, 8'd7);
      bwr(2'd1, 8'hFF);
      bwr(2'd2, 8'h01);
      wait_idle(n);
      model[33] = 8'h42;
      exp_flag = 1;
      peek(2'd0, v);
      check("R10 address frozen", v, 8'd33);
      peek(2'd1, v);
      check("R10 data frozen", v, 8'h42);
      peek(2'd2, v);
      check("R10 R8 ctrl frozen", v, ctrl_exp(0, 1, 1, 0));
      check_array(6'd33, "R10 array written");
      check_array(6'd7, "R10 other byte untouched");

      // random writes with readback
      for (int k = 0; k < 24; k++) begin
         logic [AW-1:0] a;
         logic [AW-1:0] b;
         logic [7:0] d;
         a = AW'($urandom);
         b = AW'($urandom);
         d = 8'($urandom);
         do_write(a, d, "R9 random");
         check_array(a, "R2 R9 random readback");
         check_array(b, "R2 random other byte");
      end

      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

endmodule